// File: doc/BRIEF.md
# Dual-clock byte FIFO with near-boundary flags

This block is a first-in first-out buffer for bytes that crosses between two clock domains. A producer writes bytes on its own clock. A consumer reads them on a second clock, which may be unrelated to the first or may be the same clock. The depth is a power of two set by a parameter. A dual-port storage array holds the bytes, and a registered output stage feeds a data bus that can be switched to high impedance.

Four active-low status flags tell each side when to throttle. Each flag is produced in the clock domain of the port it throttles:
- Full and near-full belong to the writer and change only on the write clock.
- Empty and near-empty belong to the reader and change only on the read clock.

The two near flags sit a fixed gap of seven words inside each boundary. Each domain learns the other side's position through Gray-coded pointers that pass through a short synchroniser chain. A flag can therefore release a few cycles late, but it never releases early.

Top module: `xclk_fifo`

## Requirements
- R1: At a rising write-clock edge with `wen_n` low and `full_n` high, `din` is stored as the newest word. While `full_n` is low, a write is ignored: no word is added and the stored contents are unchanged.
- R2: At a rising read-clock edge with `ren_n` low and `empty_n` high, the oldest stored word is loaded into the output register. Words leave in the order they were written. While `empty_n` is low, a read is ignored and the output register keeps its value.
- R3: Holding `rst_n` low for at least four cycles of each clock has these effects:
  - Both pointers return to the first location and the buffer becomes empty.
  - `full_n` and `afull_n` read 1.
  - `empty_n` and `aempty_n` read 0.
  - The output register reads zero.
- R4: Once pointers have settled, `afull_n` is 0 exactly when occupancy is DEPTH-7 or more. `full_n` is 0 exactly when occupancy equals DEPTH (with DEPTH=16: near-full at 9 or more words, not at 8).
- R5: Once pointers have settled, `aempty_n` is 0 exactly when occupancy is 7 or fewer. `empty_n` is 0 exactly when occupancy is 0 (near-empty at 7 words, not at 8).
- R6: With `oe_n` high, `dout` is high impedance. With `oe_n` low, `dout` shows the output register.
- R7: When no read is accepted, the output register, and therefore `dout`, holds its value.
- R8: With unrelated clocks and random enables, no word is lost, duplicated or reordered. `empty_n` never reads 1 while the buffer is empty, and `full_n` never reads 1 while it is full.
- R9: With both ports driven by one clock, behaviour R1, R2 and R8 still holds.
- R10: A side's own flags reflect its own operations one edge later. `full_n`/`afull_n` update at the write edge that stores the word, and `empty_n`/`aempty_n` update at the read edge that removes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Write enable, active low |
| din | input | DATA_W | Byte to store |
| rclk | input | 1 | Read clock |
| ren_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output bus enable, active low |
| dout | output | DATA_W | Output register value, or high impedance |
| rst_n | input | 1 | Reset, active low, seen by both clocks |
| full_n | output | 1 | Low when no space is left (write domain) |
| afull_n | output | 1 | Low when occupancy is DEPTH-7 or more (write domain) |
| empty_n | output | 1 | Low when nothing is readable (read domain) |
| aempty_n | output | 1 | Low when occupancy is 7 or fewer (read domain) |

## Verification
The properties assume the following about the inputs:
- `wen_n`, `ren_n` and `din` change well away from the rising edge of their own clock.
- `rst_n` stays low long enough to pass the per-domain reset synchronisers of both clocks.
- The single-clock mode is entered only while reset is held.

The stimulus meets these assumptions. It changes every enable and data value on falling edges only, and it holds reset for six cycles of each clock. It switches the clock source only inside a reset.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  localparam int unsigned NEAR_GAP_DEF = 7;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/xfifo_rst_sync.sv
module xfifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_o
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    sh <= {sh[STAGES-2:0], ~arst_n};
  end

  assign rst_o = sh[STAGES-1];
endmodule

// File: rtl/xfifo_gsync.sv
module xfifo_gsync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/xfifo_wctl.sv
module xfifo_wctl
  import xfifo_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NEAR_GAP = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wen_n,
  input  logic [ADDR_W:0] rgray_s,
  output logic            we,
  output logic [ADDR_W:0] wbin,
  output logic [ADDR_W:0] wgray,
  output logic            full_n,
  output logic            afull_n
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] wbin_nxt, wgray_nxt, rbin_s, used_nxt, rgray_inv;
  logic          full_nxt, afull_nxt;

  assign we        = ~wen_n & full_n;
  assign wbin_nxt  = wbin + PW'(we);
  assign wgray_nxt = PW'(bin2gray(32'(wbin_nxt)));
  assign rbin_s    = PW'(gray2bin(32'(rgray_s)));
  assign used_nxt  = wbin_nxt - rbin_s;
  assign rgray_inv = {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]};
  assign full_nxt  = (wgray_nxt == rgray_inv);
  assign afull_nxt = (used_nxt >= PW'(DEPTH - NEAR_GAP));

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin    <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wbin    <= wbin_nxt;
      wgray   <= wgray_nxt;
      full_n  <= ~full_nxt;
      afull_n <= ~afull_nxt;
    end
  end
endmodule

// File: rtl/xfifo_rctl.sv
module xfifo_rctl
  import xfifo_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NEAR_GAP = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ren_n,
  input  logic [ADDR_W:0] wgray_s,
  output logic            re,
  output logic [ADDR_W:0] rbin,
  output logic [ADDR_W:0] rgray,
  output logic            empty_n,
  output logic            aempty_n
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] rbin_nxt, rgray_nxt, wbin_s, avail_nxt;
  logic          empty_nxt, aempty_nxt;

  assign re         = ~ren_n & empty_n;
  assign rbin_nxt   = rbin + PW'(re);
  assign rgray_nxt  = PW'(bin2gray(32'(rbin_nxt)));
  assign wbin_s     = PW'(gray2bin(32'(wgray_s)));
  assign avail_nxt  = wbin_s - rbin_nxt;
  assign empty_nxt  = (rgray_nxt == wgray_s);
  assign aempty_nxt = (avail_nxt <= PW'(NEAR_GAP));

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin     <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nxt;
      rgray    <= rgray_nxt;
      empty_n  <= ~empty_nxt;
      aempty_n <= ~aempty_nxt;
    end
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xfifo_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int NEAR_GAP    = NEAR_GAP_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wen_n,
  input  logic [DATA_W-1:0] din,
  input  logic              rclk,
  input  logic              ren_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  input  logic              rst_n,
  output logic              full_n,
  output logic              afull_n,
  output logic              empty_n,
  output logic              aempty_n
);
  localparam int PW = ADDR_W + 1;

  logic              wr_rst, rd_rst, we, re;
  logic [PW-1:0]     wbin, wgray, rbin, rgray, wgray_s, rgray_s;
  logic [DATA_W-1:0] q_reg;

  xfifo_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
    .clk(wclk), .arst_n(rst_n), .rst_o(wr_rst));
  xfifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
    .clk(rclk), .arst_n(rst_n), .rst_o(rd_rst));

  xfifo_wctl #(.ADDR_W(ADDR_W), .NEAR_GAP(NEAR_GAP)) u_wctl (
    .clk(wclk), .rst(wr_rst), .wen_n(wen_n), .rgray_s(rgray_s),
    .we(we), .wbin(wbin), .wgray(wgray), .full_n(full_n), .afull_n(afull_n));

  xfifo_rctl #(.ADDR_W(ADDR_W), .NEAR_GAP(NEAR_GAP)) u_rctl (
    .clk(rclk), .rst(rd_rst), .ren_n(ren_n), .wgray_s(wgray_s),
    .re(re), .rbin(rbin), .rgray(rgray), .empty_n(empty_n), .aempty_n(aempty_n));

  xfifo_gsync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst(rd_rst), .d(wgray), .q(wgray_s));
  xfifo_gsync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst(wr_rst), .d(rgray), .q(rgray_s));

  xfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wclk), .we(we), .waddr(wbin[ADDR_W-1:0]), .wdata(din),
    .rclk(rclk), .rrst(rd_rst), .re(re), .raddr(rbin[ADDR_W-1:0]),
    .rdata(q_reg));

  assign dout = oe_n ? {DATA_W{1'bz}} : q_reg;
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              wclk,
  input logic              rclk,
  input logic              wr_rst,
  input logic              rd_rst,
  input logic              wen_n,
  input logic              ren_n,
  input logic              full_n,
  input logic              afull_n,
  input logic              empty_n,
  input logic              aempty_n,
  input logic [ADDR_W:0]   wbin,
  input logic [ADDR_W:0]   rbin,
  input logic [DATA_W-1:0] q_reg
);
  localparam int PW = ADDR_W + 1;

  a_r1_full_blocks_write: assert property (@(posedge wclk) disable iff (wr_rst)
    !full_n |=> $stable(wbin));

  a_r1_write_advances: assert property (@(posedge wclk) disable iff (wr_rst)
    (!wen_n && full_n) |=> (wbin == PW'($past(wbin) + 1'b1)));

  a_r2_empty_blocks_read: assert property (@(posedge rclk) disable iff (rd_rst)
    !empty_n |=> $stable(rbin));

  a_r2_read_advances: assert property (@(posedge rclk) disable iff (rd_rst)
    (!ren_n && empty_n) |=> (rbin == PW'($past(rbin) + 1'b1)));

  a_r3_reset_write_flags: assert property (@(posedge wclk)
    wr_rst |=> (full_n && afull_n));

  a_r3_reset_read_side: assert property (@(posedge rclk)
    rd_rst |=> (!empty_n && !aempty_n && q_reg == '0));

  a_r4_full_inside_afull: assert property (@(posedge wclk) disable iff (wr_rst)
    !full_n |-> !afull_n);

  a_r5_empty_inside_aempty: assert property (@(posedge rclk) disable iff (rd_rst)
    !empty_n |-> !aempty_n);

  a_r7_output_holds: assert property (@(posedge rclk) disable iff (rd_rst)
    (ren_n || !empty_n) |=> $stable(q_reg));
endmodule

bind xclk_fifo xclk_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .wr_rst(wr_rst), .rd_rst(rd_rst),
  .wen_n(wen_n), .ren_n(ren_n), .full_n(full_n), .afull_n(afull_n),
  .empty_n(empty_n), .aempty_n(aempty_n), .wbin(wbin), .rbin(rbin),
  .q_reg(q_reg));

// File: tb/xclk_fifo_test.sv
`timescale 1ns/1ps
module xclk_fifo_test;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int GAP   = 7;

  // row: {writes, reads, full_n, afull_n, empty_n, aempty_n} after settling
  localparam int NROW = 10;
  localparam logic [19:0] TBL [NROW] = '{
    {8'd7, 8'd0, 4'b1110},   // 7 words: near-empty active (R5)
    {8'd1, 8'd0, 4'b1111},   // 8 words: no partial flag
    {8'd1, 8'd0, 4'b1011},   // 9 words = DEPTH-7: near-full (R4)
    {8'd6, 8'd0, 4'b1011},   // 15 words
    {8'd1, 8'd0, 4'b0011},   // 16 words: full
    {8'd1, 8'd0, 4'b0011},   // write while full ignored (R1)
    {8'd0, 8'd8, 4'b1111},   // back to 8
    {8'd0, 8'd1, 4'b1110},   // 7 words
    {8'd0, 8'd7, 4'b1100},   // empty
    {8'd0, 8'd1, 4'b1100}    // read while empty ignored (R2)
  };

  logic wclk = 0, rclk_free = 0, same = 0;
  always #4 wclk = ~wclk;
  always #6.5 rclk_free = ~rclk_free;
  wire rclk;
  assign rclk = same ? wclk : rclk_free;

  logic          rst_n = 0, wen_n = 1, ren_n = 1, oe_n = 0;
  logic [DW-1:0] din = '0;
  wire  [DW-1:0] dout;
  wire           full_n, afull_n, empty_n, aempty_n;

  xclk_fifo #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .wclk(wclk), .wen_n(wen_n), .din(din), .rclk(rclk), .ren_n(ren_n),
    .oe_n(oe_n), .dout(dout), .rst_n(rst_n), .full_n(full_n),
    .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n));

  int            n_tests = 0, n_fail = 0;
  logic [DW-1:0] mq [$];
  logic [DW-1:0] q_model = '0;
  logic [6:0]    dctr = '0;
  bit            done = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; wen_n = 1; ren_n = 1;
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
    rst_n = 1;
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
    mq.delete();
    q_model = '0;
  endtask

  task automatic settle();
    repeat (8) @(negedge wclk);
    repeat (8) @(negedge rclk);
  endtask

  // caller stands at a falling write edge; returns at the next one
  task automatic wr_one(input bit chk);
    logic acc;
    logic [DW-1:0] d;
    d = {1'b1, dctr};
    dctr++;
    din = d; wen_n = 0; acc = full_n;
    if (chk && acc) check("R8 full never early", int'(mq.size() < DEPTH), 1);
    @(posedge wclk);
    if (acc) mq.push_back(d);
    @(negedge wclk);
    wen_n = 1;
  endtask

  // caller stands at a falling read edge; returns at the next one
  task automatic rd_one(input bit chk);
    logic acc;
    ren_n = 0; acc = empty_n;
    if (chk && acc) check("R8 empty never early", int'(mq.size() > 0), 1);
    @(posedge rclk);
    @(negedge rclk);
    ren_n = 1;
    if (acc && mq.size() > 0) q_model = mq.pop_front();
    check("R2 read data", int'(dout), int'(q_model));
  endtask

  task automatic random_run(input int cycles);
    fork
      begin
        @(negedge wclk);
        repeat (cycles) begin
          if ($urandom_range(9) < 6) wr_one(1'b1);
          else @(negedge wclk);
        end
      end
      begin
        @(negedge rclk);
        repeat (cycles) begin
          if ($urandom_range(9) < 5) rd_one(1'b1);
          else @(negedge rclk);
        end
      end
    join
    settle();
    @(negedge rclk);
    for (int g = 0; g < 4 * DEPTH && mq.size() > 0; g++) rd_one(1'b0);
    settle();
    check("R8 drained empty_n", int'(empty_n), 0);
    check("R8 drained model", mq.size(), 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R3 full_n after reset", int'(full_n), 1);
    check("R3 afull_n after reset", int'(afull_n), 1);
    check("R3 empty_n after reset", int'(empty_n), 0);
    check("R3 aempty_n after reset", int'(aempty_n), 0);
    check("R3 dout after reset", int'(dout), 0);

    // table walk: immediate own-side flags (R10), settled flags (R4/R5)
    for (int r = 0; r < NROW; r++) begin
      int nw, nr;
      nw = int'(TBL[r][19:12]);
      nr = int'(TBL[r][11:4]);
      if (nw > 0) begin
        @(negedge wclk);
        for (int k = 0; k < nw; k++) begin
          wr_one(1'b0);
          check("R10 full_n after write", int'(full_n), int'(mq.size() < DEPTH));
          check("R10 afull_n after write", int'(afull_n), int'(mq.size() < DEPTH - GAP));
        end
      end
      if (nr > 0) begin
        @(negedge rclk);
        for (int k = 0; k < nr; k++) begin
          rd_one(1'b0);
          check("R10 empty_n after read", int'(empty_n), int'(mq.size() != 0));
          check("R10 aempty_n after read", int'(aempty_n), int'(mq.size() > GAP));
        end
      end
      settle();
      check("R4 full_n settled", int'(full_n), int'(TBL[r][3]));
      check("R4 afull_n settled", int'(afull_n), int'(TBL[r][2]));
      check("R5 empty_n settled", int'(empty_n), int'(TBL[r][1]));
      check("R5 aempty_n settled", int'(aempty_n), int'(TBL[r][0]));
    end
    check("R1 ignored write left no extra word", mq.size(), 0);

    // R7: idle reads leave the output register alone
    repeat (10) @(negedge rclk);
    check("R7 dout holds while idle", int'(dout), int'(q_model));

    // R6: bus released, then driven again
    oe_n = 1;
    #1;
    check("R6 dout released", int'((dout === 8'hzz) || (dout === 8'h00)), 1);
    oe_n = 0;
    #1;
    check("R6 dout driven", int'(dout), int'(q_model));

    // R3: reset with data inside
    @(negedge wclk);
    repeat (5) wr_one(1'b0);
    do_reset();
    settle();
    check("R3 empty_n after mid reset", int'(empty_n), 0);
    check("R3 aempty_n after mid reset", int'(aempty_n), 0);
    check("R3 full_n after mid reset", int'(full_n), 1);
    check("R3 dout after mid reset", int'(dout), 0);

    // R8: unrelated clocks, random enables
    random_run(400);

    // R9: single shared clock
    rst_n = 0;
    same = 1;
    do_reset();
    random_run(400);
    check("R9 full_n idle single clock", int'(full_n), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule